// File: doc/BRIEF.md
# USB Host Start-of-Frame Scheduler

This block paces Start-of-Frame (SOF) tokens for a small USB host controller and owns the 11-bit frame number carried in each of them. Software loads the frame number through a narrow register port, releases the controller reset bit, selects the SOF token type and sets the token enable. From then on a period timer asks an external packet engine for one SOF per period. Each request raises a busy flag, and the engine's completion pulse clears it and advances the frame number.

The current frame number and its CRC5 leave the block as parallel fields for the serializer. While an SOF is in flight the frame number cannot be overwritten by software. While the controller reset bit is high the timer is held and the number does not advance.

Top module: `sof_sched`

## Requirements
- R1: After `rst_n` is low, `frame_num` is 0, `sof_busy` is 0 and `sof_req` is 0.
- R2: `rd_data[10:0]` always equals `frame_num` and `rd_data[15:11]` always reads 0; the value written to `wr_data[15:11]` has no effect.
- R3: A write (`wr_en`=1) while `sof_busy`=0 loads `wr_data[10:0]` into `frame_num` at the next clock edge, whatever the value of `ctrl_rst`.
- R4: A write while `sof_busy`=1 is ignored and `frame_num` keeps its value.
- R5: The timer runs only while `tok_en`=1, `tok_type`=2'b01 (SOF) and `ctrl_rst`=0. The first `sof_req` pulse (one cycle wide) appears `PERIOD` cycles after the timer starts. Later ticks follow every `PERIOD` cycles in the same phase.
- R6: `sof_busy` rises in the same cycle as `sof_req`. It falls in the cycle after a `pkt_done` pulse is sampled.
- R7: A `pkt_done` sampled while `sof_busy`=1 and `ctrl_rst`=0 increments `frame_num` by exactly 1, wrapping from 2047 to 0. A `pkt_done` sampled while `sof_busy`=0 changes nothing.
- R8: While `ctrl_rst`=1 no `sof_req` is issued. A `pkt_done` during that time still clears `sof_busy` but leaves `frame_num` unchanged.
- R9: Clearing `tok_en`, or selecting a token type other than 2'b01, stops the timer and any further request. An SOF already in flight still completes and increments the frame number.
- R10: `frame_crc5` is the USB token CRC5 of `frame_num`: bits taken LSB first, generator x^5+x^2+1, register preset to 5'b11111, result inverted.
- R11: A timer tick that falls while `sof_busy`=1 issues no request. The timer keeps its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Frame register write strobe |
| wr_data | input | 16 | Frame register write data |
| rd_data | output | 16 | Frame register read value |
| ctrl_rst | input | 1 | Controller reset bit; high holds timer and counter |
| tok_en | input | 1 | Token generation enable |
| tok_type | input | 2 | Token type select, 2'b01 = SOF |
| pkt_done | input | 1 | Packet engine completion pulse |
| sof_req | output | 1 | One-cycle SOF request to the packet engine |
| sof_busy | output | 1 | SOF in flight |
| frame_num | output | 11 | Current frame number |
| frame_crc5 | output | 5 | CRC5 of the frame number |

## Verification
The bench builds the block with `PERIOD` set to 8. This puts first-request latency, steady pacing, a tick colliding with a busy SOF, and controller-reset and enable gating within a few dozen cycles each. All 2048 frame values are written in turn, with the reserved bits set. After each write the readback and the CRC5 are checked against a reflected shift-right computation made in the bench. The wrap from 2047 to 0 is reached by loading 2046 and completing two SOFs.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int FRAME_W = 11;
  localparam int CRC_W   = 5;
  localparam logic [1:0] TOK_SOF = 2'b01;
  localparam logic [CRC_W-1:0] CRC_POLY   = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_PRESET = 5'b11111;

  // Token CRC5: data LSB first, MSB-first shift register, inverted result.
  function automatic logic [CRC_W-1:0] crc5_of(input logic [FRAME_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = CRC_PRESET;
    for (int i = 0; i < FRAME_W; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return ~c;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_next(input logic [FRAME_W-1:0] f);
    return f + 1'b1;
  endfunction
endpackage

// File: rtl/sof_tick_timer.sv
module sof_tick_timer #(
  parameter int PERIOD = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sof_frame_reg.sv
module sof_frame_reg
  import sof_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               inc,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frame <= '0;
    else if (load)  frame <= load_val;
    else if (inc)   frame <= frame_next(frame);
  end
endmodule

// File: rtl/sof_crc5_gen.sv
module sof_crc5_gen
  import sof_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output logic [CRC_W-1:0]   crc
);
  assign crc = crc5_of(frame);
endmodule

// File: rtl/sof_sched.sv
module sof_sched
  import sof_pkg::*;
#(
  parameter int PERIOD = 48000,
  parameter int REG_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  ctrl_rst,
  input  logic                  tok_en,
  input  logic [1:0]            tok_type,
  input  logic                  pkt_done,
  output logic                  sof_req,
  output logic                  sof_busy,
  output logic [FRAME_W-1:0]    frame_num,
  output logic [CRC_W-1:0]      frame_crc5
);
  localparam int PAD_W = REG_W - FRAME_W;

  // Named internal events, visible to the bound checker.
  logic run_evt;
  logic tick_evt;
  logic issue_evt;
  logic write_evt;
  logic inc_evt;

  assign run_evt   = tok_en && (tok_type == TOK_SOF) && !ctrl_rst;
  assign issue_evt = tick_evt && !sof_busy;
  assign write_evt = wr_en && !sof_busy;
  assign inc_evt   = pkt_done && sof_busy && !ctrl_rst;

  sof_tick_timer #(.PERIOD(PERIOD)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_evt),
    .tick (tick_evt)
  );

  sof_frame_reg u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (write_evt),
    .load_val(wr_data[FRAME_W-1:0]),
    .inc     (inc_evt),
    .frame   (frame_num)
  );

  sof_crc5_gen u_crc (
    .frame(frame_num),
    .crc  (frame_crc5)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_req  <= 1'b0;
      sof_busy <= 1'b0;
    end else begin
      sof_req <= issue_evt;
      if (issue_evt)     sof_busy <= 1'b1;
      else if (pkt_done) sof_busy <= 1'b0;
    end
  end

  assign rd_data = {{PAD_W{1'b0}}, frame_num};
endmodule

// File: rtl/sof_sched_chk.sv
module sof_sched_chk
  import sof_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               ctrl_rst,
  input logic               tok_en,
  input logic [1:0]         tok_type,
  input logic               pkt_done,
  input logic               sof_req,
  input logic               sof_busy,
  input logic [FRAME_W-1:0] frame_num,
  input logic [REG_W-1:0]   rd_data,
  input logic               tick_evt,
  input logic               inc_evt
);
  // R2
  rd_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == {{(REG_W-FRAME_W){1'b0}}, frame_num});

  // R4
  busy_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sof_busy && !pkt_done) |=> $stable(frame_num));

  // R6
  req_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req |-> sof_busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_busy && !pkt_done) |=> sof_busy);

  // R6
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_busy && pkt_done) |=> !sof_busy);

  // R7
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !wr_en) |=> frame_num == FRAME_W'($past(frame_num) + 1));

  // R8
  ctrl_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rst && !wr_en) |=> $stable(frame_num));

  // R5
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_en || tok_type != TOK_SOF || ctrl_rst) |=> !sof_req);

  // R11
  tick_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && sof_busy) |=> !sof_req);

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req |=> !sof_req);
endmodule

bind sof_sched sof_sched_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .ctrl_rst (ctrl_rst),
  .tok_en   (tok_en),
  .tok_type (tok_type),
  .pkt_done (pkt_done),
  .sof_req  (sof_req),
  .sof_busy (sof_busy),
  .frame_num(frame_num),
  .rd_data  (rd_data),
  .tick_evt (tick_evt),
  .inc_evt  (inc_evt)
);

// File: tb/sim_sof_sched.sv
module sim_sof_sched;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        ctrl_rst = 1'b1;
  logic        tok_en = 1'b0;
  logic [1:0]  tok_type = 2'b00;
  logic        pkt_done = 1'b0;
  logic        sof_req;
  logic        sof_busy;
  logic [10:0] frame_num;
  logic [4:0]  frame_crc5;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sof_sched #(.PERIOD(P), .REG_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ctrl_rst(ctrl_rst), .tok_en(tok_en), .tok_type(tok_type), .pkt_done(pkt_done),
    .sof_req(sof_req), .sof_busy(sof_busy), .frame_num(frame_num), .frame_crc5(frame_crc5)
  );

  // Reflected (shift-right) form of the token CRC, bit-reversed at the end.
  function automatic logic [4:0] ref_crc(input logic [10:0] d);
    logic [4:0] r, o;
    r = 5'h1f;
    for (int i = 0; i < 11; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 5'b10100;
      else             r = r >> 1;
    end
    for (int i = 0; i < 5; i++) o[i] = r[4-i];
    return ~o;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_frame(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); pkt_done = 1'b1;
    @(negedge clk); pkt_done = 1'b0;
  endtask

  // Counts negedges until sof_req is seen, up to lim.
  task automatic wait_req(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!sof_req && n < lim);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, c0;
    logic [10:0] f;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 frame", 32'(frame_num), 0);
    chk("R1 busy", 32'(sof_busy), 0);
    chk("R1 req", 32'(sof_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R10 sweep of every frame value, reserved bits set, ctrl_rst=1
    for (int v = 0; v < 2048; v++) begin
      write_frame({5'b10110 ^ 5'(v), 11'(v)});
      chk("R3 load", 32'(frame_num), 32'(v));
      chk("R2 readback", 32'(rd_data), 32'(v));
      chk("R10 crc5", 32'(frame_crc5), 32'(ref_crc(11'(v))));
    end

    write_frame(16'hF7FE);   // 2046
    tok_type = 2'b01; tok_en = 1'b1;
    // R8 no request while controller reset high
    wait_req(3*P, n);
    chk("R8 no req under ctrl_rst", 32'(sof_req), 0);

    // R5 first request one full period after start
    @(negedge clk); ctrl_rst = 1'b0;
    wait_req(3*P, n);
    c0 = cyc;
    chk("R5 first req latency", 32'(n), 32'(P));
    chk("R6 busy with req", 32'(sof_busy), 1);
    @(negedge clk);
    chk("R5 req one cycle", 32'(sof_req), 0);

    // R4 write during busy ignored
    write_frame(16'h0005);
    chk("R4 write blocked", 32'(frame_num), 32'd2046);

    // R11 ticks during busy give no request
    wait_req(2*P, n);
    chk("R11 no req while busy", 32'(sof_req), 0);

    // R7 R6 completion
    done_pulse();
    chk("R7 increment", 32'(frame_num), 32'd2047);
    chk("R6 busy falls", 32'(sof_busy), 0);
    wait_req(2*P, n);
    chk("R11 phase kept", 32'((cyc - c0) % P), 0);
    chk("R5 next req", 32'(sof_req), 1);
    done_pulse();
    chk("R7 wrap", 32'(frame_num), 0);
    done_pulse();
    chk("R7 done when idle ignored", 32'(frame_num), 0);

    // R5 steady pacing
    wait_req(2*P, n);
    c0 = cyc;
    done_pulse();
    wait_req(2*P, n);
    chk("R5 period", 32'(cyc - c0), 32'(P));
    chk("R7 count", 32'(frame_num), 1);

    // R9 disable with SOF in flight
    @(negedge clk); tok_en = 1'b0;
    wait_req(2*P, n);
    chk("R9 stopped", 32'(sof_req), 0);
    done_pulse();
    chk("R9 in-flight completes", 32'(frame_num), 2);
    @(negedge clk); tok_en = 1'b1; tok_type = 2'b10;
    wait_req(3*P, n);
    chk("R9 other type no req", 32'(sof_req), 0);

    // R8 completion under controller reset
    @(negedge clk); tok_type = 2'b01;
    wait_req(3*P, n);
    chk("R5 restart latency", 32'(n), 32'(P));
    f = frame_num;
    @(negedge clk); ctrl_rst = 1'b1;
    done_pulse();
    chk("R8 no increment", 32'(frame_num), 32'(f));
    chk("R8 busy cleared", 32'(sof_busy), 0);
    finish_run();
  end
endmodule